// File: doc/BRIEF.md
# Dual-Channel Edge Event Controller

This block is the digital control front end of a charge and time measurement unit. It watches two event channels. Each channel takes one of four sources: two external pins, which are resynchronised on entry, or two trigger pulses from on-chip capture/compare units, which are already synchronous. After a per-channel polarity is applied, each channel is judged on its present level and not on a transition. A recognised event sets a sticky per-channel status flag. The block drives a current-source enable that is high from the first-channel event until the second-channel event.

An optional ordering filter discards second-channel events until a first-channel event has been recorded. A small write-only register port holds the channel selects, the polarities, the ordering and enable bits, and a range and trim setting that passes straight to the analog current source. The same port clears the status flags by writing zeros.

Top module: `edge_event_ctrl`

## Requirements
- R1: After reset, `evt_stat`, `isrc_en`, `isrc_range` and `isrc_trim` are all zero, and the module is disabled.
- R2: A write to address 0 loads the control byte. Bit 0 is module enable. Bit 1 is sequence enable. Bits 3:2 are the channel-1 source and bit 4 is the channel-1 polarity. Bits 6:5 are the channel-2 source and bit 7 is the channel-2 polarity. Source code 0 selects `pin_in[0]`, 1 selects `pin_in[1]`, 2 selects `trig_in[0]` and 3 selects `trig_in[1]`. Polarity 1 makes a high level the event and polarity 0 makes a low level the event.
- R3: Detection uses the input level. If a control write makes the selected input already sit at the active level, the status flag sets on the clock edge after the write.
- R4: An active level on a trigger input sets its status flag on the next clock edge. An active level on a pin sets its flag on the third clock edge after the pin changes, because the pin first passes through two synchroniser flops.
- R5: Status flags are sticky. A write to address 1 clears channel 1 when bit 0 is 0 and clears channel 2 when bit 1 is 0. A 1 in either bit leaves that flag unchanged. A clear wins over a simultaneous event, so a flag whose input is still active reads 0 for one cycle and then sets again.
- R6: With sequence enable set, a channel-2 event is accepted only when the channel-1 flag was already set before that clock edge. An earlier channel-2 event is discarded and leaves no trace.
- R7: `isrc_en` is high exactly while the channel-1 flag is set and the channel-2 flag is clear.
- R8: While module enable is 0, both flags are held at 0 from the next clock edge, all channel inputs are ignored, and `isrc_en` stays low.
- R9: A write to address 2 loads the range in bits 1:0 and a two's-complement trim in bits 7:2, where 000000 is neutral, 100000 is the largest negative step and 011111 is the largest positive step. These values appear on `isrc_range` and `isrc_trim` from the write edge onward. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pin_in | input | 2 | Asynchronous external event pins |
| trig_in | input | 2 | Synchronous capture/compare trigger pulses |
| evt_stat | output | 2 | Sticky status flags, bit 0 for channel 1 and bit 1 for channel 2 |
| isrc_en | output | 1 | Current-source enable |
| isrc_range | output | 2 | Current range setting |
| isrc_trim | output | 6 | Two's-complement current trim |

## Verification
Each result has a fixed latency. Range and trim, and a status clear, show up in the cycle the write lands. A flag set by a trigger, or by a reconfiguration, shows one edge later. A flag set by a pin shows three edges after the pin moves. The driver enqueues every expectation tagged with the exact cycle it is due. The monitor compares only in that cycle, half a period after the edge. For pin events it also checks the cycle before the due cycle, so an early flag is caught as well as a late one.

// File: rtl/eec_pkg.sv
// Shared types and register addresses for the edge event controller.
// Assumes an 8-bit register port with 2-bit addressing.
package eec_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int NUM_CH = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CUR  = 2'd2;

    // Control byte, MSB first: ch2 pol, ch2 src, ch1 pol, ch1 src, seq, enable
    typedef struct packed {
        logic       ch2_pol;
        logic [1:0] ch2_src;
        logic       ch1_pol;
        logic [1:0] ch1_src;
        logic       seq_en;
        logic       mod_en;
    } ctrl_t;

    // Current-source byte: trim above range
    typedef struct packed {
        logic [5:0] trim;
        logic [1:0] range;
    } cur_t;
endpackage

// File: rtl/eec_sync.sv
// Multi-stage synchroniser for asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is implied.
module eec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pin levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/eec_cfg.sv
// Configuration registers: control and current bytes, plus status clear strobes.
// Assumes writes are single-cycle strobes; address 3 is unused.
module eec_cfg
    import eec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_o,
    output cur_t              cur_o,
    output logic [NUM_CH-1:0] clr_o
);
    // Hold the control and current bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
            cur_o  <= '0;
        end else if (we) begin
            if (addr == ADDR_CTRL) ctrl_o <= ctrl_t'(wdata);
            if (addr == ADDR_CUR)  cur_o  <= cur_t'(wdata);
        end
    end

    // A zero bit written to the status address clears that channel
    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            clr_o[c] = we && (addr == ADDR_STAT) && !wdata[c];
    end
endmodule

// File: rtl/eec_level.sv
// One channel's source selector and polarity stage.
// Assumes all sources are already synchronous to clk.
module eec_level #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] srcs,
    input  logic [SEL_W-1:0]   sel,
    input  logic               pol,
    output logic               active
);
    // Active when the chosen level equals the polarity setting
    always_comb active = (srcs[sel] == pol);
endmodule

// File: rtl/edge_event_ctrl.sv
// Two-channel level event controller with sticky status and current-source enable.
// Assumes pin_in is asynchronous and trig_in is synchronous to clk.
module edge_event_ctrl
    import eec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [1:0]        pin_in,
    input  logic [1:0]        trig_in,
    output logic [NUM_CH-1:0] evt_stat,
    output logic              isrc_en,
    output logic [1:0]        isrc_range,
    output logic [5:0]        isrc_trim
);
    localparam int NUM_SRC = 4;

    ctrl_t              ctrl;
    cur_t               cur;
    logic [NUM_CH-1:0]  clr_w;
    logic [1:0]         pin_s;
    logic [NUM_SRC-1:0] srcs;
    logic [NUM_CH-1:0]  lvl;
    logic [NUM_CH-1:0]  hit;
    logic [NUM_CH-1:0]  stat_q;
    logic               mod_en_w;
    logic               seq_en_w;

    eec_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .ctrl_o(ctrl), .cur_o(cur), .clr_o(clr_w)
    );

    eec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pin_s)
    );

    assign srcs     = {trig_in, pin_s};
    assign mod_en_w = ctrl.mod_en;
    assign seq_en_w = ctrl.seq_en;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            eec_level #(.NUM_SRC(NUM_SRC)) u_lvl (
                .srcs  (srcs),
                .sel   ((g == 0) ? ctrl.ch1_src : ctrl.ch2_src),
                .pol   ((g == 0) ? ctrl.ch1_pol : ctrl.ch2_pol),
                .active(lvl[g])
            );

            // Sticky flag: disable and clear win over a new event
            always_ff @(posedge clk) begin
                if (!rst_n)         stat_q[g] <= 1'b0;
                else if (!mod_en_w) stat_q[g] <= 1'b0;
                else if (clr_w[g])  stat_q[g] <= 1'b0;
                else if (hit[g])    stat_q[g] <= 1'b1;
            end
        end
    endgenerate

    // Channel 2 passes the ordering filter only after channel 1 is recorded
    always_comb begin
        hit[0] = lvl[0];
        hit[1] = lvl[1] && (!seq_en_w || stat_q[0]);
    end

    assign evt_stat   = stat_q;
    assign isrc_en    = stat_q[0] && !stat_q[1];
    assign isrc_range = cur.range;
    assign isrc_trim  = cur.trim;
endmodule

// File: rtl/eec_checker.sv
// Property checker for edge_event_ctrl, attached by bind.
// Assumes it samples the top's ports and a few internal control nets.
module eec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mod_en,
    input logic       seq_en,
    input logic [1:0] clr,
    input logic [1:0] evt_stat,
    input logic       isrc_en
);
    AST_OFF_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (evt_stat == 2'b00)); // R8
    AST_EN_NEEDS_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        isrc_en |-> evt_stat[0]); // R7
    AST_EN_OFF_AFTER_CH2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stat[1] |-> !isrc_en); // R7
    AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_stat[1]) && $past(seq_en)) |-> $past(evt_stat[0])); // R6
    AST_STICKY_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_stat[0]) |-> $past(clr[0] || !mod_en)); // R5
    AST_STICKY_CH2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_stat[1]) |-> $past(clr[1] || !mod_en)); // R5
endmodule

bind edge_event_ctrl eec_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en_w), .seq_en(seq_en_w),
    .clr(clr_w), .evt_stat(evt_stat), .isrc_en(isrc_en)
);

// File: tb/tb_edge_event_ctrl.sv
module tb_edge_event_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] pin_in = 2'b01;
    logic [1:0] trig_in = 2'b00;
    logic [1:0] evt_stat;
    logic       isrc_en;
    logic [1:0] isrc_range;
    logic [5:0] isrc_trim;

    int cyc = 0;
    int total = 0;
    int bad = 0;

    typedef struct {
        int    due;
        int    kind;   // 0 status, 1 enable, 2 {trim,range}
        int    exp;
        string req;
    } item_t;
    item_t sbq[$];

    edge_event_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pin_in(pin_in), .trig_in(trig_in),
        .evt_stat(evt_stat), .isrc_en(isrc_en), .isrc_range(isrc_range),
        .isrc_trim(isrc_trim)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                int act;
                case (sbq[i].kind)
                    0:       act = int'(evt_stat);
                    1:       act = int'(isrc_en);
                    default: act = int'({isrc_trim, isrc_range});
                endcase
                total++;
                if (act != sbq[i].exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d cyc=%0d actual=%0h expected=%0h",
                             sbq[i].req, sbq[i].kind, cyc, act, sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic push(input int d, input int kind, input int exp, input string req);
        item_t it;
        it.due = cyc + d; it.kind = kind; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        push(0, 0, 0, "R1"); push(0, 1, 0, "R1"); push(0, 2, 0, "R1");
        tick(1);

        // R8: disabled module ignores an active trigger
        trig_in = 2'b01;
        wr(2'd0, 8'hF8);
        push(1, 0, 0, "R8"); push(2, 0, 0, "R8");
        tick(3);

        // R3 / R2: enabling with trigger already high sets ch1 one edge later
        wr(2'd0, 8'hF9);
        push(1, 0, 1, "R3"); push(1, 1, 1, "R7");
        tick(2);
        trig_in = 2'b00;
        tick(2);
        push(0, 0, 1, "R5");   // sticky after input drops

        // R4 trigger latency, R7 enable falls on ch2
        trig_in = 2'b10;
        push(1, 0, 3, "R4"); push(1, 1, 0, "R7");
        tick(1);
        trig_in = 2'b00;
        tick(1);

        // R5 clear both flags
        wr(2'd1, 8'h00);
        push(0, 0, 0, "R5");
        tick(1);

        // R5 clear while input active re-sets next clock
        trig_in = 2'b01;
        push(1, 0, 1, "R4");
        tick(2);
        wr(2'd1, 8'h02);
        push(0, 0, 0, "R5"); push(1, 0, 1, "R5");
        tick(2);
        trig_in = 2'b00;
        wr(2'd1, 8'h03);
        push(0, 0, 1, "R5");   // writing ones has no effect
        tick(1);
        wr(2'd1, 8'h00);
        push(0, 0, 0, "R5");
        tick(1);

        // R6 sequence filter
        wr(2'd0, 8'hFB);
        trig_in = 2'b10;
        push(1, 0, 0, "R6");
        tick(1);
        trig_in = 2'b00;
        push(1, 0, 0, "R6");
        tick(2);
        trig_in = 2'b10;
        push(2, 0, 0, "R6");
        tick(3);
        trig_in = 2'b11;
        push(1, 0, 1, "R6"); push(1, 1, 1, "R7");
        push(2, 0, 3, "R6"); push(2, 1, 0, "R7");
        tick(3);
        trig_in = 2'b00;

        // R4 pin path through synchroniser, active-low ch1 on pin 0
        wr(2'd0, 8'hA1);
        wr(2'd1, 8'h00);
        push(0, 0, 0, "R5"); push(1, 0, 0, "R2");
        tick(2);
        pin_in = 2'b00;
        push(2, 0, 0, "R4"); push(3, 0, 1, "R4");
        tick(4);

        // R3 polarity change makes pin 1 (low) active at once
        wr(2'd0, 8'h21);
        push(1, 0, 3, "R3"); push(1, 1, 0, "R7");
        tick(2);

        // R8 disable clears and ignores inputs
        wr(2'd0, 8'h20);
        push(1, 0, 0, "R8"); push(3, 0, 0, "R8"); push(3, 1, 0, "R8");
        trig_in = 2'b11;
        tick(4);
        trig_in = 2'b00;

        // R9 range and trim pass-through, address 3 ignored
        wr(2'd2, 8'h83);
        push(0, 2, 8'h83, "R9");
        tick(1);
        wr(2'd2, 8'h7C);
        push(0, 2, 8'h7C, "R9");
        tick(1);
        wr(2'd3, 8'hFF);
        push(0, 2, 8'h7C, "R9");
        tick(3);

        if (sbq.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sbq.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule